// File: doc/BRIEF.md
# Fast-Off Inactivity Timer

This block decides when a system has been idle long enough to be powered down. A down-counter is loaded from a software-set reload value. It counts ticks whose granularity comes from a two-bit select: one PCI clock, one millisecond or one minute. A fourth code turns the timer off. A prescaler derives the millisecond and minute ticks from a PCI-clock tick enable, so the counter runs on the same clock as the rest of the logic.

Activity is reported through an event vector. It carries the interrupt lines, NMI and SMI, and each bit has a system-event mask and a break-event mask. Any enabled system event restarts the count, which keeps the system awake. When the count runs out, the block gives a single-cycle expiry pulse to the SMI logic, reloads itself and counts again. A separate stop-clock machine drives an active-low stop-clock request. Software asserts that request, and the first enabled break event releases it. INTR is a separate input that can act only as a break event.

The counter machine has three states. CS_LOAD is entered at reset and copies the reload value. It moves to CS_RUN, or to CS_HOLD if the timer is off. CS_RUN moves to CS_HOLD when the off code is selected. CS_HOLD moves back to CS_RUN when any other code is selected. The stop-clock machine has two states. SC_AWAKE moves to SC_STOPPED on a software request. SC_STOPPED moves back to SC_AWAKE on an enabled break event.

Top module: `fastoff_timer`

## Requirements
- R1: While reset is held, `count` is 0, `expire` is 0 and `stpclk_n` is 1. On the first clock edge after reset is released, `count` takes the value of `reload_val`.
- R2: With `gran` = 2'b10, every cycle in which `pci_tick` is high decrements `count` by one.
- R3: With `gran` = 2'b11, `count` decrements once every MS_DIV PCI ticks.
- R4: With `gran` = 2'b00, `count` decrements once every MS_DIV*MIN_DIV PCI ticks.
- R5: A selected tick that arrives while `count` is 1 or less sets `expire` high for exactly one cycle. In that same cycle `count` shows the reload value.
- R6: A bit of `ev_in` that is high while its bit in `sys_en` is set reloads `count` from `reload_val` on the next edge. This takes priority over a pending tick, so no expiry pulse is produced.
- R7: An `ev_in` bit whose `sys_en` bit is clear has no effect on `count`.
- R8: With `gran` = 2'b01, `count` is frozen, `expire` stays 0 and system events are ignored. When another code is selected, counting resumes after one cycle.
- R9: A change of `reload_val` does not alter `count` until the next reload.
- R10: `stop_req` while `stpclk_n` is 1 drives `stpclk_n` to 0 on the next edge. It stays 0 until a break event occurs.
- R11: While `stpclk_n` is 0, an `ev_in` bit that is high with its `brk_en` bit set returns `stpclk_n` to 1 on the next edge. `stop_req` is ignored in that state.
- R12: `intr_in` with `intr_brk_en` set wakes the stop-clock machine. `intr_in` never reloads the counter.
- R13: Break sources whose mask bit is clear leave `stpclk_n` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pci_tick | input | 1 | One-cycle PCI tick enable feeding the prescaler and the PCI granularity |
| gran | input | 2 | Granularity: 00 minute, 01 off, 10 PCI clock, 11 millisecond |
| reload_val | input | CNT_W | Initial value of the count |
| ev_in | input | EV_N | Activity sources (interrupt lines, NMI, SMI) |
| sys_en | input | EV_N | Per-source system-event mask |
| brk_en | input | EV_N | Per-source break-event mask |
| intr_in | input | 1 | INTR, which is a break-only source |
| intr_brk_en | input | 1 | Break mask for INTR |
| stop_req | input | 1 | Software request to stop the clock |
| count | output | CNT_W | Current count |
| expire | output | 1 | One-cycle expiry pulse |
| stpclk_n | output | 1 | Active-low stop-clock request |

## Verification
The count is driven through every granularity code with a continuous PCI tick. The spacing between decrements tells the PCI, millisecond and minute sources apart, and the off code shows up as a frozen count. Enabled, masked and break-only events are applied at points chosen so that each result differs from the one a plain decrement would give. One enabled event lands exactly on the expiring tick, to separate reload priority from expiry. A reload-value change is made mid-count, so that an early load would show. A table of stop-clock vectors alternates sleep requests with enabled and masked wake sources, including a sleep request issued together with a break event.

// File: rtl/fot_pkg.sv
package fot_pkg;

    typedef enum logic [1:0] {
        GR_MINUTE = 2'b00,
        GR_OFF    = 2'b01,
        GR_PCICLK = 2'b10,
        GR_MSEC   = 2'b11
    } gran_e;

    typedef enum logic [1:0] {
        CS_LOAD = 2'b00,
        CS_RUN  = 2'b01,
        CS_HOLD = 2'b10
    } cnt_state_e;

    typedef enum logic {
        SC_AWAKE   = 1'b0,
        SC_STOPPED = 1'b1
    } clk_state_e;

endpackage

// File: rtl/fot_prescale.sv
module fot_prescale #(
    parameter int MS_DIV  = 33000,
    parameter int MIN_DIV = 60000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pci_tick,
    output logic ms_tick,
    output logic min_tick
);
    localparam int MS_W  = (MS_DIV  > 1) ? $clog2(MS_DIV)  : 1;
    localparam int MIN_W = (MIN_DIV > 1) ? $clog2(MIN_DIV) : 1;
    localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(MS_DIV - 1);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MIN_DIV - 1);

    logic [MS_W-1:0]  ms_cnt;
    logic [MIN_W-1:0] min_cnt;

    // Stage one: PCI ticks to milliseconds.
    assign ms_tick  = pci_tick && (ms_cnt == MS_LAST);
    // Stage two: milliseconds to minutes.
    assign min_tick = ms_tick && (min_cnt == MIN_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ms_cnt <= '0;
        end else if (pci_tick) begin
            ms_cnt <= (ms_cnt == MS_LAST) ? '0 : ms_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min_cnt <= '0;
        end else if (ms_tick) begin
            min_cnt <= (min_cnt == MIN_LAST) ? '0 : min_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fot_event_merge.sv
module fot_event_merge #(
    parameter int EV_N = 18
) (
    input  logic [EV_N-1:0] ev_in,
    input  logic [EV_N-1:0] sys_en,
    input  logic [EV_N-1:0] brk_en,
    input  logic            intr_in,
    input  logic            intr_brk_en,
    output logic            sys_hit,
    output logic            brk_hit
);
    logic [EV_N-1:0] sys_vec;
    logic [EV_N-1:0] brk_vec;

    for (genvar i = 0; i < EV_N; i++) begin : g_src
        assign sys_vec[i] = ev_in[i] & sys_en[i];
        assign brk_vec[i] = ev_in[i] & brk_en[i];
    end

    assign sys_hit = |sys_vec;
    // INTR joins the break path only.
    assign brk_hit = (|brk_vec) | (intr_in & intr_brk_en);

endmodule

// File: rtl/fot_down_counter.sv
module fot_down_counter
    import fot_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  gran_e            gran,
    input  logic             tick_pci,
    input  logic             tick_ms,
    input  logic             tick_min,
    input  logic             sys_hit,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire,
    output logic             tick,
    output cnt_state_e       state
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             exp_q, exp_d;
    logic             off;

    assign off = (gran == GR_OFF);

    always_comb begin
        unique case (gran)
            GR_MINUTE: tick = tick_min;
            GR_OFF:    tick = 1'b0;
            GR_PCICLK: tick = tick_pci;
            GR_MSEC:   tick = tick_ms;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CS_LOAD;
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            exp_q <= exp_d;
        end
    end

    // Next state and count
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        exp_d = 1'b0;
        unique case (st_q)
            CS_LOAD: begin
                cnt_d = reload_val;
                st_d  = off ? CS_HOLD : CS_RUN;
            end
            CS_RUN: begin
                if (off) begin
                    st_d = CS_HOLD;
                end else if (sys_hit) begin
                    cnt_d = reload_val;
                end else if (tick) begin
                    if (cnt_q <= ONE) begin
                        cnt_d = reload_val;
                        exp_d = 1'b1;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            end
            CS_HOLD: begin
                if (!off) st_d = CS_RUN;
            end
            default: st_d = CS_LOAD;
        endcase
    end

    // Outputs
    always_comb begin
        count  = cnt_q;
        expire = exp_q;
        state  = st_q;
    end

endmodule

// File: rtl/fot_stopclk.sv
module fot_stopclk
    import fot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic brk_hit,
    output logic stpclk_n
);
    clk_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SC_AWAKE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SC_AWAKE:   if (stop_req) st_d = SC_STOPPED;
            SC_STOPPED: if (brk_hit)  st_d = SC_AWAKE;
        endcase
    end

    always_comb begin
        stpclk_n = (st_q == SC_AWAKE);
    end

endmodule

// File: rtl/fastoff_timer.sv
module fastoff_timer
    import fot_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int EV_N    = 18,
    parameter int MS_DIV  = 33000,
    parameter int MIN_DIV = 60000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pci_tick,
    input  logic [1:0]       gran,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [EV_N-1:0]  ev_in,
    input  logic [EV_N-1:0]  sys_en,
    input  logic [EV_N-1:0]  brk_en,
    input  logic             intr_in,
    input  logic             intr_brk_en,
    input  logic             stop_req,
    output logic [CNT_W-1:0] count,
    output logic             expire,
    output logic             stpclk_n
);
    logic       ms_tick, min_tick;
    logic       sys_hit, brk_hit;
    logic       tick_sel;
    cnt_state_e cnt_st;

    fot_prescale #(.MS_DIV(MS_DIV), .MIN_DIV(MIN_DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .pci_tick (pci_tick),
        .ms_tick  (ms_tick),
        .min_tick (min_tick)
    );

    fot_event_merge #(.EV_N(EV_N)) u_ev (
        .ev_in       (ev_in),
        .sys_en      (sys_en),
        .brk_en      (brk_en),
        .intr_in     (intr_in),
        .intr_brk_en (intr_brk_en),
        .sys_hit     (sys_hit),
        .brk_hit     (brk_hit)
    );

    fot_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .gran       (gran_e'(gran)),
        .tick_pci   (pci_tick),
        .tick_ms    (ms_tick),
        .tick_min   (min_tick),
        .sys_hit    (sys_hit),
        .reload_val (reload_val),
        .count      (count),
        .expire     (expire),
        .tick       (tick_sel),
        .state      (cnt_st)
    );

    fot_stopclk u_sc (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_req (stop_req),
        .brk_hit  (brk_hit),
        .stpclk_n (stpclk_n)
    );

endmodule

// File: rtl/fot_checker.sv
module fot_checker
    import fot_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int EV_N  = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       gran,
    input logic [CNT_W-1:0] reload_val,
    input logic [EV_N-1:0]  ev_in,
    input logic [EV_N-1:0]  sys_en,
    input logic [EV_N-1:0]  brk_en,
    input logic             intr_in,
    input logic             intr_brk_en,
    input logic             stop_req,
    input logic [CNT_W-1:0] count,
    input logic             expire,
    input logic             stpclk_n,
    input logic             tick_sel,
    input cnt_state_e       cnt_st
);
    logic sys_any, brk_any, is_off;
    assign sys_any = |(ev_in & sys_en);
    assign brk_any = (|(ev_in & brk_en)) | (intr_in & intr_brk_en);
    assign is_off  = (gran == 2'b01);

    p_load_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_st == CS_LOAD) |=> (count == $past(reload_val)));

    p_decrement_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_st == CS_RUN && !is_off && !sys_any && tick_sel && count > CNT_W'(1))
        |=> (count == $past(count) - CNT_W'(1)));

    p_expire_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (count == $past(reload_val)));

    p_expire_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> $past(tick_sel));

    p_sys_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_st == CS_RUN && !is_off && sys_any)
        |=> (count == $past(reload_val) && !expire));

    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_st != CS_LOAD && is_off) |=> ($stable(count) && !expire));

    p_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stpclk_n && stop_req) |=> !stpclk_n);

    p_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!stpclk_n && brk_any) |=> stpclk_n);

    p_stay_asleep_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!stpclk_n && !brk_any) |=> !stpclk_n);

endmodule

bind fastoff_timer fot_checker #(.CNT_W(CNT_W), .EV_N(EV_N)) i_fot_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .gran        (gran),
    .reload_val  (reload_val),
    .ev_in       (ev_in),
    .sys_en      (sys_en),
    .brk_en      (brk_en),
    .intr_in     (intr_in),
    .intr_brk_en (intr_brk_en),
    .stop_req    (stop_req),
    .count       (count),
    .expire      (expire),
    .stpclk_n    (stpclk_n),
    .tick_sel    (tick_sel),
    .cnt_st      (cnt_st)
);

// File: tb/test_fastoff_timer.sv
module test_fastoff_timer;
    localparam int CNT_W   = 16;
    localparam int EV_N    = 18;
    localparam int MS_DIV  = 4;
    localparam int MIN_DIV = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             pci_tick;
    logic [1:0]       gran;
    logic [CNT_W-1:0] reload_val;
    logic [EV_N-1:0]  ev_in, sys_en, brk_en;
    logic             intr_in, intr_brk_en, stop_req;
    logic [CNT_W-1:0] count;
    logic             expire, stpclk_n;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    fastoff_timer #(.CNT_W(CNT_W), .EV_N(EV_N), .MS_DIV(MS_DIV), .MIN_DIV(MIN_DIV)) i_fastoff_timer (
        .clk(clk), .rst_n(rst_n), .pci_tick(pci_tick), .gran(gran),
        .reload_val(reload_val), .ev_in(ev_in), .sys_en(sys_en), .brk_en(brk_en),
        .intr_in(intr_in), .intr_brk_en(intr_brk_en), .stop_req(stop_req),
        .count(count), .expire(expire), .stpclk_n(stpclk_n)
    );

    // Stop-clock vectors: stop_req, ev_in, brk_en, intr_in, intr_brk_en, expected stpclk_n, requirement number
    localparam int VW = 1 + EV_N + EV_N + 1 + 1 + 1 + 4;
    localparam int NV = 10;
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 18'h00000, 18'h00000, 1'b0, 1'b0, 1'b1, 4'd10}, // R10 idle stays awake
        {1'b1, 18'h00000, 18'h00000, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 request stops
        {1'b0, 18'h00000, 18'h00000, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 stays stopped
        {1'b0, 18'h00010, 18'h00000, 1'b0, 1'b0, 1'b0, 4'd13}, // R13 masked source
        {1'b0, 18'h00010, 18'h00010, 1'b0, 1'b0, 1'b1, 4'd11}, // R11 enabled source wakes
        {1'b1, 18'h00000, 18'h00000, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 stop again
        {1'b0, 18'h00000, 18'h00000, 1'b1, 1'b0, 1'b0, 4'd13}, // R13 masked INTR
        {1'b0, 18'h00000, 18'h00000, 1'b1, 1'b1, 1'b1, 4'd12}, // R12 INTR wakes
        {1'b1, 18'h00001, 18'h00001, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 request wins while awake
        {1'b1, 18'h20000, 18'h20000, 1'b0, 1'b0, 1'b1, 4'd11}  // R11 break wins while stopped
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic measure_gap(output int gap);
        logic [CNT_W-1:0] prev;
        int n;
        prev = count;
        n = 0;
        while (count == prev && n < 100) begin step(); n++; end
        prev = count;
        n = 0;
        do begin step(); n++; end while (count == prev && n < 100);
        gap = n;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int gap;
        rst_n = 1'b0; pci_tick = 1'b0; gran = 2'b10; reload_val = 16'd5;
        ev_in = '0; sys_en = '0; brk_en = '0;
        intr_in = 1'b0; intr_brk_en = 1'b0; stop_req = 1'b0;
        repeat (3) step();
        // R1 reset state
        check("R1 count", count, 0);
        check("R1 expire", expire, 0);
        check("R1 stpclk_n", stpclk_n, 1);
        rst_n = 1'b1;
        step();
        check("R1 load", count, 5);

        // R2 PCI-clock decrement
        pci_tick = 1'b1;
        for (int v = 4; v >= 1; v--) begin
            step();
            check("R2 decrement", count, v);
            check("R2 no expire", expire, 0);
        end
        // R5 expiry and reload
        step();
        check("R5 expire", expire, 1);
        check("R5 reload", count, 5);
        step();
        check("R5 single pulse", expire, 0);
        check("R5 count", count, 4);

        // R6 system event reload
        sys_en = 18'h00008; ev_in = 18'h00008;
        step();
        check("R6 reload", count, 5);
        ev_in = '0;
        repeat (4) step();
        check("R6 setup", count, 1);
        ev_in = 18'h00008;
        step();
        check("R6 priority count", count, 5);
        check("R6 priority expire", expire, 0);

        // R7 masked system event
        ev_in = 18'h00020;
        step();
        check("R7 masked", count, 4);
        ev_in = '0;

        // R12 INTR never reloads
        intr_in = 1'b1; intr_brk_en = 1'b1;
        step();
        check("R12 no reload", count, 3);
        intr_in = 1'b0; intr_brk_en = 1'b0;

        // R9 reload value change deferred
        reload_val = 16'd9;
        step();
        check("R9 not early", count, 2);
        step();
        check("R9 not early", count, 1);
        step();
        check("R9 expire", expire, 1);
        check("R9 new value", count, 9);

        // R8 off code freezes
        gran = 2'b01; ev_in = 18'h00008;
        for (int k = 0; k < 4; k++) begin
            step();
            check("R8 frozen", count, 9);
            check("R8 no expire", expire, 0);
        end
        ev_in = '0; gran = 2'b10;
        step();
        check("R8 resume delay", count, 9);
        step();
        check("R8 resumed", count, 8);

        // R3 millisecond ticks
        reload_val = 16'd200; ev_in = 18'h00008;
        step();
        check("R3 setup", count, 200);
        ev_in = '0; gran = 2'b11;
        measure_gap(gap);
        check("R3 ms spacing", gap, MS_DIV);

        // R4 minute ticks
        gran = 2'b00;
        measure_gap(gap);
        check("R4 minute spacing", gap, MS_DIV * MIN_DIV);

        // Stop-clock table: R10 R11 R12 R13
        gran = 2'b01; sys_en = '0;
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            stop_req    = v[VW-1];
            ev_in       = v[VW-2 -: EV_N];
            brk_en      = v[VW-2-EV_N -: EV_N];
            intr_in     = v[6];
            intr_brk_en = v[5];
            step();
            check($sformatf("R%0d vector %0d", v[3:0], i), stpclk_n, v[4]);
        end
        stop_req = 1'b0; ev_in = '0; brk_en = '0; intr_in = 1'b0; intr_brk_en = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule